// File: doc/BRIEF.md
# Multichannel DAC Serial Input Router

This block takes serial audio for eight DAC channels, organised as four stereo pairs, and turns it into eight parallel sample words. It runs on the serial bit clock. Each rising edge of that clock samples the frame clock and the data lines. Samples are twos complement and sent MSB first. The first bit of a word arrives one bit clock after the frame-clock edge that opens its slot. Every slot is 32 bit clocks long.

There are two input formats. In the four-line stereo format, data line p carries pair p. The left word follows a falling frame-clock edge, and the right word follows a rising edge. In the single-line packed format, line 0 carries a 256-bit frame that opens at a rising frame-clock edge. It holds eight 32-bit slots in channel order.

A replicate switch sends the first pair's left and right words to every pair. This is how one high-rate stream can feed all the outputs. The format, the replicate switch and the word width are taken in only at frame starts. Each frame is therefore decoded under a single setting.

Top module: `dac_serial_router`

## Requirements
- R1: While reset is low, every output word is zero and the strobe is low. The mode inputs present during reset become the active setting.
- R2: In stereo format (tdm_mode=0), line p feeds channel 2p (left) from the bit after a falling frame-clock edge, and channel 2p+1 (right) from the bit after a rising edge.
- R3: In packed format (tdm_mode=1), the frame opens one bit after a rising frame-clock edge. Slot k (bits 32k..32k+31) feeds channel k, with channel 2p the left and 2p+1 the right of pair p. Lines 1 to 3 are ignored.
- R4: width_sel encodes the word width: 0 gives 16 bits, 1 gives 20 bits, 2 or 3 gives 24 bits. Each word is left-justified into the 24-bit output with zeros below it. Slot bits past the width are ignored.
- R5: With replicate active for a frame, every pair outputs the words received in slots 0 and 1 (pair 0).
- R6: A frame is complete when its next start edge arrives (a falling edge in stereo after 64 bits, a rising edge in packed after 256 bits). Then all eight words update together, and frame_valid is high for exactly one cycle, the cycle after that edge. At all other times the words hold.
- R7: Changes to tdm_mode, replicate and width_sel inside a frame have no effect on that frame. They are taken at the start edge that closes it.
- R8: A frame whose start edge arrives before all of its bits produces no strobe and leaves the words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck | input | 1 | Frame clock (low = left in stereo format) |
| sdin | input | 4 | Serial data lines, one per pair; only bit 0 used in packed format |
| tdm_mode | input | 1 | 1 selects the single-line packed format |
| replicate | input | 1 | 1 copies pair 0 to all pairs |
| width_sel | input | 2 | Word width code (see R4) |
| words | output | 192 | Eight 24-bit words; channel k at bits 24k+23..24k |
| frame_valid | output | 1 | One-cycle strobe when the words update |

## Verification
The frame-closing edge does two jobs in the same cycle. It publishes the finished frame under that frame's own setting, and it loads the setting for the next frame. The bench provokes this collision by changing width and replicate midway through a frame, and by switching between the stereo and packed formats across frame boundaries. It judges the strobed words against expectations built from the outgoing frame's width and replicate choice. The next frame is checked under the new setting.

// File: rtl/dac_router_pkg.sv
package dac_router_pkg;

   typedef enum logic [1:0] {
      WS_16  = 2'd0,
      WS_20  = 2'd1,
      WS_24  = 2'd2,
      WS_24B = 2'd3
   } wsel_e;

   typedef struct packed {
      logic  tdm;
      logic  replicate;
      wsel_e wsel;
   } mode_t;

   function automatic int unsigned word_bits(wsel_e w);
      case (w)
         WS_16:   return 16;
         WS_20:   return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
   import dac_router_pkg::*;
#(
   parameter int PAIRS     = 4,
   parameter int SLOT_BITS = 32,
   localparam int POS_W    = $clog2(2 * PAIRS * SLOT_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lrck,
   input  mode_t            mode_in,
   output mode_t            mode_act,
   output logic [POS_W-1:0] pos,
   output logic             frame_done
);

   localparam logic [POS_W-1:0] STEREO_LAST = POS_W'(2 * SLOT_BITS - 1);
   localparam logic [POS_W-1:0] TDM_LAST    = '1;
   localparam logic [POS_W-1:0] RIGHT_START = POS_W'(SLOT_BITS);

   logic  lrck_q;
   logic  sync_q;
   logic  fall, rise, start_cur;
   mode_t nxt;

   assign fall      = lrck_q & ~lrck;
   assign rise      = ~lrck_q & lrck;
   assign start_cur = mode_act.tdm ? rise : fall;
   assign nxt       = start_cur ? mode_in : mode_act;
   assign frame_done = start_cur && sync_q &&
                       (pos == (mode_act.tdm ? TDM_LAST : STEREO_LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lrck_q   <= lrck;
         mode_act <= mode_in;
         sync_q   <= 1'b0;
         pos      <= '1;
      end else begin
         lrck_q   <= lrck;
         mode_act <= nxt;
         if ((nxt.tdm && rise) || (!nxt.tdm && fall)) begin
            pos    <= '0;
            sync_q <= 1'b1;
         end else if (!nxt.tdm && rise) begin
            pos <= RIGHT_START;
            if (start_cur) sync_q <= 1'b0;
         end else begin
            if (start_cur) sync_q <= 1'b0;
            if (pos != '1) pos <= pos + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dac_chan_capture.sv
module dac_chan_capture #(
   parameter int OUT_W   = 24,
   parameter int SLOT_LG = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [SLOT_LG-1:0] idx,
   input  logic [SLOT_LG:0]   wbits,
   input  logic               sd,
   output logic [OUT_W-1:0]   word
);

   localparam logic [OUT_W-1:0] TOP_BIT = {1'b1, {(OUT_W-1){1'b0}}};

   logic [OUT_W-1:0] sel;
   assign sel = TOP_BIT >> idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
      end else if (en) begin
         if (idx == '0)
            word <= sd ? TOP_BIT : '0;
         else if ({1'b0, idx} < wbits)
            word <= sd ? (word | sel) : (word & ~sel);
      end
   end

endmodule

// File: rtl/dac_serial_router.sv
module dac_serial_router
   import dac_router_pkg::*;
#(
   parameter int PAIRS     = 4,
   parameter int SLOT_BITS = 32,
   parameter int OUT_W     = 24
) (
   input  logic                       bclk,
   input  logic                       rst_n,
   input  logic                       lrck,
   input  logic [PAIRS-1:0]           sdin,
   input  logic                       tdm_mode,
   input  logic                       replicate,
   input  logic [1:0]                 width_sel,
   output logic [2*PAIRS*OUT_W-1:0]   words,
   output logic                       frame_valid
);

   localparam int NCH     = 2 * PAIRS;
   localparam int SLOT_LG = $clog2(SLOT_BITS);
   localparam int POS_W   = $clog2(NCH * SLOT_BITS);
   localparam int CH_W    = $clog2(NCH);

   if (OUT_W < 24 || OUT_W > SLOT_BITS) begin : g_bad_width
      $error("OUT_W must hold a 24-bit word and fit a slot");
   end
   if ((SLOT_BITS & (SLOT_BITS - 1)) != 0) begin : g_bad_slot
      $error("SLOT_BITS must be a power of two");
   end
   if (PAIRS < 2 || (PAIRS & (PAIRS - 1)) != 0) begin : g_bad_pairs
      $error("PAIRS must be a power of two of at least 2");
   end

   mode_t              mode_in, mode_act;
   logic [POS_W-1:0]   pos;
   logic               done;
   logic [SLOT_LG:0]   wbits;
   logic [SLOT_LG-1:0] idx;
   logic [CH_W-1:0]    slot;
   logic               in_span;
   logic               rep_act;
   logic [1:0]         wsel_act;
   logic [OUT_W-1:0]   cap [NCH];

   assign mode_in.tdm       = tdm_mode;
   assign mode_in.replicate = replicate;
   assign mode_in.wsel      = wsel_e'(width_sel);

   dac_frame_ctrl #(.PAIRS(PAIRS), .SLOT_BITS(SLOT_BITS)) u_ctrl (
      .clk(bclk), .rst_n(rst_n), .lrck(lrck), .mode_in(mode_in),
      .mode_act(mode_act), .pos(pos), .frame_done(done)
   );

   assign wbits    = (SLOT_LG + 1)'(word_bits(mode_act.wsel));
   assign idx      = pos[SLOT_LG-1:0];
   assign slot     = pos[POS_W-1:SLOT_LG];
   assign in_span  = (slot[CH_W-1:1] == '0);
   assign rep_act  = mode_act.replicate;
   assign wsel_act = mode_act.wsel;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic en, line;
      assign en   = mode_act.tdm ? (slot == CH_W'(ch))
                                 : (in_span && (slot[0] == ch[0]));
      assign line = mode_act.tdm ? sdin[0] : sdin[ch / 2];

      dac_chan_capture #(.OUT_W(OUT_W), .SLOT_LG(SLOT_LG)) u_cap (
         .clk(bclk), .rst_n(rst_n), .en(en), .idx(idx), .wbits(wbits),
         .sd(line), .word(cap[ch])
      );

      logic [OUT_W-1:0] src;
      if (ch < 2) begin : g_direct
         assign src = cap[ch];
      end else begin : g_fanout
         assign src = mode_act.replicate ? cap[ch % 2] : cap[ch];
      end

      always_ff @(posedge bclk) begin
         if (!rst_n)    words[ch*OUT_W +: OUT_W] <= '0;
         else if (done) words[ch*OUT_W +: OUT_W] <= src;
      end
   end

   always_ff @(posedge bclk) begin
      if (!rst_n) frame_valid <= 1'b0;
      else        frame_valid <= done;
   end

endmodule

// File: rtl/dac_router_chk.sv
module dac_router_chk #(
   parameter int PAIRS = 4,
   parameter int OUT_W = 24
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     lrck,
   input logic                     frame_valid,
   input logic [2*PAIRS*OUT_W-1:0] words,
   input logic                     rep_act,
   input logic [1:0]               wsel_act
);

   localparam int NCH = 2 * PAIRS;

   logic [NCH-1:0] low8_set, low4_set;
   for (genvar ch = 0; ch < NCH; ch++) begin : g_low
      assign low8_set[ch] = |words[ch*OUT_W + (OUT_W-24) +: 8];
      assign low4_set[ch] = |words[ch*OUT_W + (OUT_W-24) +: 4];
   end

   // R6: strobe lasts one cycle
   p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   // R6: words only move with the strobe
   p_words_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> $stable(words));

   // R6: a strobe always follows a frame-clock edge
   p_strobe_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> ($past(lrck) != $past(lrck, 2)));

   // R4: zero fill below a 16-bit word
   p_zero_fill16_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && $past(wsel_act) == 2'd0) |-> (low8_set == '0));

   // R4: zero fill below a 20-bit word
   p_zero_fill20_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && $past(wsel_act) == 2'd1) |-> (low4_set == '0));

   // R5: every pair mirrors pair 0
   for (genvar p = 1; p < PAIRS; p++) begin : g_rep
      p_replicate_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (frame_valid && $past(rep_act)) |->
         (words[2*p*OUT_W +: 2*OUT_W] == words[0 +: 2*OUT_W]));
   end

endmodule

bind dac_serial_router dac_router_chk #(.PAIRS(PAIRS), .OUT_W(OUT_W)) u_chk (
   .clk(bclk), .rst_n(rst_n), .lrck(lrck), .frame_valid(frame_valid),
   .words(words), .rep_act(rep_act), .wsel_act(wsel_act)
);

// File: tb/tb_dac_serial_router.sv
module tb_dac_serial_router;

   localparam int NCH = 8;
   localparam int OW  = 24;

   logic          clk = 1'b0;
   logic          rst_n, lrck, tdm, rep;
   logic [1:0]    ws;
   logic [3:0]    sd;
   logic [NCH*OW-1:0] words;
   logic          fv;

   always #4 clk = ~clk;

   dac_serial_router dut (
      .bclk(clk), .rst_n(rst_n), .lrck(lrck), .sdin(sd), .tdm_mode(tdm),
      .replicate(rep), .width_sel(ws), .words(words), .frame_valid(fv)
   );

   int checks = 0, bad = 0, frames_seen = 0, frames_exp = 0;
   logic [OW-1:0]     exp_w [NCH];
   logic              pend = 1'b0;
   string             pend_tag = "";
   logic [NCH*OW-1:0] last_words = '0;
   logic              cur_pk = 1'b0;
   logic              finished = 1'b0;

   // {tdm, replicate, width code, seed}
   localparam logic [35:0] VEC [8] = '{
      {1'b0, 1'b0, 2'd2, 32'h1234_5678},
      {1'b0, 1'b0, 2'd0, 32'hCAFE_0001},
      {1'b0, 1'b1, 2'd1, 32'h0BAD_F00D},
      {1'b1, 1'b0, 2'd2, 32'h7777_1111},
      {1'b1, 1'b1, 2'd0, 32'h5A5A_A5A5},
      {1'b1, 1'b0, 2'd1, 32'h0F0F_3C3C},
      {1'b0, 1'b0, 2'd3, 32'hDEAD_BEEF},
      {1'b0, 1'b1, 2'd2, 32'h2468_ACE0}
   };

   function automatic logic [OW-1:0] gen(logic [31:0] seed, int ch);
      logic [31:0] x;
      x = seed ^ (32'h9E37_79B9 * (ch + 1));
      x = x ^ (x >> 13);
      return x[23:0];
   endfunction

   function automatic int wbits(logic [1:0] w);
      return (w == 2'd0) ? 16 : (w == 2'd1) ? 20 : 24;
   endfunction

   function automatic logic sbit(logic [OW-1:0] v, int w, int idx);
      return (idx < w) ? v[23 - idx] : 1'b1;
   endfunction

   task automatic fail(string tag, string what, logic [OW-1:0] act, logic [OW-1:0] expv);
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
   endtask

   task automatic observe();
      checks++;
      if (fv) begin
         frames_seen++;
         if (!pend) begin
            bad++;
            $display("FAIL R8 strobe with no complete frame actual=1 expected=0");
         end else begin
            for (int ch = 0; ch < NCH; ch++)
               if (words[ch*OW +: OW] !== exp_w[ch]) begin
                  fail(pend_tag, $sformatf("channel %0d", ch), words[ch*OW +: OW], exp_w[ch]);
                  break;
               end
         end
         pend = 1'b0;
         last_words = words;
      end else if (words !== last_words) begin
         bad++;
         $display("FAIL R6 words moved without strobe actual=%h expected=%h", words, last_words);
         last_words = words;
      end
   endtask

   task automatic set_modes(logic p, logic r, logic [1:0] w);
      tdm = p; rep = r; ws = w;
   endtask

   task automatic gap(logic level, logic p, logic r, logic [1:0] w);
      @(negedge clk);
      observe();
      set_modes(p, r, w);
      lrck = level;
      sd = '0;
   endtask

   task automatic send_frame(logic p, logic r, logic [1:0] w, logic [31:0] seed,
                             int chg_t, logic np, logic nr, logic [1:0] nw,
                             int trunc, string tag);
      logic [OW-1:0] src [NCH];
      int n, wd;
      n  = p ? 256 : 64;
      wd = wbits(w);
      for (int ch = 0; ch < NCH; ch++) src[ch] = gen(seed, ch);
      if (p != cur_pk) gap(p ? 1'b0 : 1'b1, p, r, w);
      for (int t = 0; t < n; t++) begin
         int pos, idx, sl;
         if (trunc > 0 && t == trunc) break;
         @(negedge clk);
         observe();
         if (t == 0) set_modes(p, r, w);
         if (chg_t > 0 && t == chg_t) set_modes(np, nr, nw);
         pos = (t + n - 1) % n;
         idx = pos % 32;
         sl  = pos / 32;
         if (p) begin
            lrck  = (t < 128);
            sd[0] = sbit(src[sl], wd, idx);
            sd[3:1] = pos[0] ? 3'b101 : 3'b010;
         end else begin
            lrck = (t >= 32);
            for (int l = 0; l < 4; l++) sd[l] = sbit(src[2*l + sl], wd, idx);
         end
      end
      cur_pk = p;
      if (trunc == 0) begin
         for (int ch = 0; ch < NCH; ch++)
            exp_w[ch] = src[ch] & (24'hFF_FFFF << (24 - wd));
         if (r) for (int ch = 2; ch < NCH; ch++) exp_w[ch] = exp_w[ch % 2];
         pend = 1'b1;
         pend_tag = tag;
         frames_exp++;
      end
   endtask

   task automatic do_reset(string why);
      @(negedge clk);
      rst_n = 1'b0; lrck = 1'b1; sd = '0;
      set_modes(1'b0, 1'b0, 2'd2);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (i > 0) begin
            checks++;
            if (words !== '0 || fv !== 1'b0) begin
               bad++;
               $display("FAIL R1 %s reset state actual=%h/%b expected=0/0", why, words, fv);
            end
         end
      end
      rst_n = 1'b1;
      last_words = '0;
      pend = 1'b0;
      cur_pk = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; lrck = 1'b1; sd = '0;
      set_modes(1'b0, 1'b0, 2'd2);
      do_reset("power-up");

      // table of frames, each checked when the next start edge closes it
      for (int v = 0; v < 8; v++) begin
         logic p, r; logic [1:0] w;
         string tag;
         p = VEC[v][35]; r = VEC[v][34]; w = VEC[v][33:32];
         tag = $sformatf("%s%s%s", p ? "R3" : "R2", r ? " R5" : "", (w < 2) ? " R4" : "");
         send_frame(p, r, w, VEC[v][31:0], 0, 1'b0, 1'b0, 2'd0, 0, tag);
      end

      // R7: width and replicate flipped mid-frame, decoded under the old setting
      send_frame(1'b0, 1'b0, 2'd2, 32'h1357_9BDF, 10, 1'b0, 1'b1, 2'd0, 0, "R7 old setting");
      send_frame(1'b0, 1'b1, 2'd0, 32'hFACE_B00C, 0, 1'b0, 1'b0, 2'd0, 0, "R7 new setting R5 R4");

      // R7: packed request mid stereo frame does not alter it
      send_frame(1'b0, 1'b0, 2'd2, 32'h0A0B_0C0D, 20, 1'b1, 1'b0, 2'd2, 0, "R7 format held R2");
      send_frame(1'b1, 1'b0, 2'd2, 32'h1111_2222, 0, 1'b0, 1'b0, 2'd0, 0, "R7 packed after switch R3");
      send_frame(1'b1, 1'b0, 2'd0, 32'h3333_4444, 0, 1'b0, 1'b0, 2'd0, 0, "R3 R4");

      // R8: truncated stereo frame emits nothing, next full frame still decoded
      send_frame(1'b0, 1'b0, 2'd2, 32'h9999_0000, 0, 1'b0, 1'b0, 2'd0, 40, "R8");
      send_frame(1'b0, 1'b0, 2'd2, 32'h8888_7777, 0, 1'b0, 1'b0, 2'd0, 0, "R8 recovery R2");
      send_frame(1'b0, 1'b0, 2'd1, 32'h4242_4242, 0, 1'b0, 1'b0, 2'd0, 0, "R2 R4");

      // R1: reset in the middle of a frame
      send_frame(1'b0, 1'b0, 2'd2, 32'h6666_5555, 0, 1'b0, 1'b0, 2'd0, 20, "R1");
      do_reset("mid-frame");
      send_frame(1'b0, 1'b1, 2'd2, 32'h7070_0707, 0, 1'b0, 1'b0, 2'd0, 0, "R1 after reset R5");
      send_frame(1'b0, 1'b0, 2'd0, 32'h1F2E_3D4C, 0, 1'b0, 1'b0, 2'd0, 0, "R1 after reset R4");

      // closing edge for the last frame, then a quiet tail
      gap(1'b0, 1'b0, 1'b0, 2'd0);
      for (int i = 0; i < 3; i++) gap(1'b0, 1'b0, 1'b0, 2'd0);

      checks++;
      if (frames_seen != frames_exp) begin
         bad++;
         $display("FAIL R8 strobe count actual=%0d expected=%0d", frames_seen, frames_exp);
      end
      checks++;
      if (pend) begin
         bad++;
         $display("FAIL R6 last frame never strobed actual=0 expected=1");
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule